// File: doc/BRIEF.md
# Page Cache Line-Valid Lookup

This block sits between a node's shared-miss path and its network port for pages that are replicated into local memory. A table indexed by local page number holds, for each page, a mapping enable, the global page number it mirrors, and one valid bit per cache line. A miss to a mapped page either finds its line present and is told to read local memory, or is turned into a remote fetch carrying the global page number. When the remote line comes back, the block translates its global page back to the local page, marks the line present and tells the datapath to write it locally and hand it to the requester.

Software programs mappings through a plain write port and releases a page through a flush request. The flush walks the page's bitmap and emits one flush item per present line, lowest line first, and leaves the page unmapped. Incoming invalidations name a global page and a line; a match clears that line. Lookups and fills enter on valid/ready streams, and all results leave on one valid/ready result stream held by a single output register. An item is held unchanged while `out_ready` is low, and no lookup or fill is taken while that item is pending and not being consumed in the same cycle.

Top module: `pcl_lookup`

## Requirements
- R1: After reset the result stream is empty, `flush_busy` and `unmapped_err` are low, and every page is unmapped.
- R2: A lookup to a mapped page whose line bit is set produces a result with code 0 (local hit) carrying the local page, its global page and the line; no remote fetch is issued.
- R3: A lookup to a mapped page whose line bit is clear produces a result with code 1 (remote fetch) carrying the translated global page and the line, and leaves the bit clear.
- R4: A lookup to an unmapped page (never written, or written with enable low) is consumed, produces no result item, and pulses `unmapped_err` high for the one cycle after acceptance.
- R5: A fill whose global page matches an enabled mapping sets that line's bit and produces a result with code 2 (local write) carrying the local page found by reverse translation.
- R6: A fill whose global page matches no enabled mapping is consumed with no result item and no bit change.
- R7: An invalidation whose global page matches an enabled mapping clears only the named line's bit.
- R8: A mapping write sets the page's global page and enable and clears its whole bitmap, even when the global page is unchanged.
- R9: A flush request emits one result with code 3 per set line of the page in ascending line order, clears those bits, unmaps the page and drops `flush_busy` when no set line remains.
- R10: While `out_valid` is high and `out_ready` low, the result item stays unchanged and `req_ready` and `fill_ready` stay low.
- R11: A pending fill takes precedence over a pending lookup in the same cycle, and neither stream is accepted while `flush_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mapping write strobe |
| cfg_lpn | input | LPN_W | Local page to program |
| cfg_gpn | input | GPN_W | Global page for the mapping |
| cfg_en | input | 1 | Mapping enable value |
| flush_req | input | 1 | Start a flush of `flush_lpn` (ignored while busy) |
| flush_lpn | input | LPN_W | Local page to flush |
| flush_busy | output | 1 | Flush walk in progress |
| inv_valid | input | 1 | Invalidation strobe, always taken |
| inv_gpn | input | GPN_W | Global page of the invalidation |
| inv_line | input | LN_W | Line of the invalidation |
| req_valid | input | 1 | Lookup valid |
| req_ready | output | 1 | Lookup accepted this cycle when high with valid |
| req_lpn | input | LPN_W | Lookup local page |
| req_line | input | LN_W | Lookup line |
| fill_valid | input | 1 | Remote fill valid |
| fill_ready | output | 1 | Fill accepted this cycle when high with valid |
| fill_gpn | input | GPN_W | Global page of the fill |
| fill_line | input | LN_W | Line of the fill |
| out_valid | output | 1 | Result item valid |
| out_ready | input | 1 | Consumer takes the result item |
| out_code | output | 2 | 0 local hit, 1 remote fetch, 2 local write, 3 flush line |
| out_lpn | output | LPN_W | Local page of the item |
| out_gpn | output | GPN_W | Global page of the item |
| out_line | output | LN_W | Line of the item |
| unmapped_err | output | 1 | One-cycle pulse for a lookup to an unmapped page |

## Verification
The properties take for granted that software never maps two enabled local pages to the same global page, that stream inputs stay stable while valid and not ready, and that a flush request is only raised when `flush_busy` is low. The bench maps distinct global pages, holds each request until the cycle after it sees ready, and pulses flush only from an idle state. Within that envelope the checker ties each newly loaded result code to the stream or flush walk that must have produced it in the previous cycle, and checks holding under back-pressure and the blocking of both input streams during a flush.

// File: rtl/pcl_pkg.sv
`timescale 1ns/1ps
package pcl_pkg;
  typedef enum logic [1:0] {
    RES_LOCAL = 2'd0,
    RES_FETCH = 2'd1,
    RES_FILL  = 2'd2,
    RES_FLUSH = 2'd3
  } pcl_code_e;
endpackage

// File: rtl/pcl_table.sv
`timescale 1ns/1ps
module pcl_table #(
  parameter int NPAGE = 4,
  parameter int LINES = 8,
  parameter int GPN_W = 12,
  localparam int LPN_W = $clog2(NPAGE),
  localparam int LN_W  = $clog2(LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [LPN_W-1:0]            cfg_lpn,
  input  logic [GPN_W-1:0]            cfg_gpn,
  input  logic                        cfg_en,
  input  logic                        set_v,
  input  logic [LPN_W-1:0]            set_pg,
  input  logic [LN_W-1:0]             set_ln,
  input  logic                        fclr_v,
  input  logic [LPN_W-1:0]            fclr_pg,
  input  logic [LN_W-1:0]             fclr_ln,
  input  logic                        iclr_v,
  input  logic [LPN_W-1:0]            iclr_pg,
  input  logic [LN_W-1:0]             iclr_ln,
  input  logic                        dis_v,
  input  logic [LPN_W-1:0]            dis_pg,
  output logic [NPAGE-1:0]            en_vec,
  output logic [NPAGE-1:0][GPN_W-1:0] gpn_tab,
  output logic [NPAGE-1:0][LINES-1:0] bit_tab
);
  for (genvar i = 0; i < NPAGE; i++) begin : g_page
    logic [LINES-1:0] setm, clrm;
    always_comb begin
      setm = '0;
      clrm = '0;
      if (set_v  && set_pg  == LPN_W'(i)) setm[set_ln]  = 1'b1;
      if (fclr_v && fclr_pg == LPN_W'(i)) clrm[fclr_ln] = 1'b1;
      if (iclr_v && iclr_pg == LPN_W'(i)) clrm[iclr_ln] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_vec[i]  <= 1'b0;
        gpn_tab[i] <= '0;
        bit_tab[i] <= '0;
      end else if (cfg_we && cfg_lpn == LPN_W'(i)) begin
        en_vec[i]  <= cfg_en;
        gpn_tab[i] <= cfg_gpn;
        bit_tab[i] <= '0;
      end else begin
        if (dis_v && dis_pg == LPN_W'(i)) en_vec[i] <= 1'b0;
        bit_tab[i] <= (bit_tab[i] | setm) & ~clrm;
      end
    end
  end
endmodule

// File: rtl/pcl_rev_match.sv
`timescale 1ns/1ps
module pcl_rev_match #(
  parameter int NPAGE = 4,
  parameter int GPN_W = 12,
  localparam int LPN_W = $clog2(NPAGE)
) (
  input  logic [NPAGE-1:0]            en_vec,
  input  logic [NPAGE-1:0][GPN_W-1:0] gpn_tab,
  input  logic [GPN_W-1:0]            key,
  output logic                        hit,
  output logic [LPN_W-1:0]            idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NPAGE - 1; i >= 0; i--) begin
      if (en_vec[i] && gpn_tab[i] == key) begin
        hit = 1'b1;
        idx = LPN_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcl_first_set.sv
`timescale 1ns/1ps
module pcl_first_set #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pcl_lookup.sv
`timescale 1ns/1ps
module pcl_lookup
  import pcl_pkg::*;
#(
  parameter int NPAGE = 4,
  parameter int LINES = 8,
  parameter int GPN_W = 12,
  localparam int LPN_W = $clog2(NPAGE),
  localparam int LN_W  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LPN_W-1:0] cfg_lpn,
  input  logic [GPN_W-1:0] cfg_gpn,
  input  logic             cfg_en,
  input  logic             flush_req,
  input  logic [LPN_W-1:0] flush_lpn,
  output logic             flush_busy,
  input  logic             inv_valid,
  input  logic [GPN_W-1:0] inv_gpn,
  input  logic [LN_W-1:0]  inv_line,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LPN_W-1:0] req_lpn,
  input  logic [LN_W-1:0]  req_line,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [GPN_W-1:0] fill_gpn,
  input  logic [LN_W-1:0]  fill_line,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_code,
  output logic [LPN_W-1:0] out_lpn,
  output logic [GPN_W-1:0] out_gpn,
  output logic [LN_W-1:0]  out_line,
  output logic             unmapped_err
);
  logic [NPAGE-1:0]            en_vec;
  logic [NPAGE-1:0][GPN_W-1:0] gpn_tab;
  logic [NPAGE-1:0][LINES-1:0] bit_tab;

  logic             busy_q, err_q, ov_q;
  logic [LPN_W-1:0] fl_pg;
  pcl_code_e        code_q;
  logic [LPN_W-1:0] lpn_q;
  logic [GPN_W-1:0] gpn_q;
  logic [LN_W-1:0]  line_q;

  logic             can_emit, fire_fill, fire_req, walk_emit;
  logic             fm_hit, im_hit, fs_any;
  logic [LPN_W-1:0] fm_idx, im_idx;
  logic [LN_W-1:0]  fs_idx;
  logic             r_en, r_bit;

  assign can_emit   = !ov_q || out_ready;
  assign fill_ready = !busy_q && can_emit;
  assign req_ready  = !busy_q && can_emit && !fill_valid;
  assign fire_fill  = fill_valid && fill_ready;
  assign fire_req   = req_valid && req_ready;
  assign walk_emit  = busy_q && can_emit && fs_any;
  assign r_en       = en_vec[req_lpn];
  assign r_bit      = bit_tab[req_lpn][req_line];

  pcl_table #(.NPAGE(NPAGE), .LINES(LINES), .GPN_W(GPN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_lpn(cfg_lpn), .cfg_gpn(cfg_gpn), .cfg_en(cfg_en),
    .set_v(fire_fill && fm_hit), .set_pg(fm_idx), .set_ln(fill_line),
    .fclr_v(walk_emit), .fclr_pg(fl_pg), .fclr_ln(fs_idx),
    .iclr_v(inv_valid && im_hit), .iclr_pg(im_idx), .iclr_ln(inv_line),
    .dis_v(flush_req && !busy_q), .dis_pg(flush_lpn),
    .en_vec(en_vec), .gpn_tab(gpn_tab), .bit_tab(bit_tab)
  );

  pcl_rev_match #(.NPAGE(NPAGE), .GPN_W(GPN_W)) u_fill_match (
    .en_vec(en_vec), .gpn_tab(gpn_tab), .key(fill_gpn), .hit(fm_hit), .idx(fm_idx)
  );

  pcl_rev_match #(.NPAGE(NPAGE), .GPN_W(GPN_W)) u_inv_match (
    .en_vec(en_vec), .gpn_tab(gpn_tab), .key(inv_gpn), .hit(im_hit), .idx(im_idx)
  );

  pcl_first_set #(.W(LINES)) u_walk (
    .vec(bit_tab[fl_pg]), .any(fs_any), .idx(fs_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fl_pg  <= '0;
      err_q  <= 1'b0;
      ov_q   <= 1'b0;
      code_q <= RES_LOCAL;
      lpn_q  <= '0;
      gpn_q  <= '0;
      line_q <= '0;
    end else begin
      if (busy_q) begin
        if (can_emit && !fs_any) busy_q <= 1'b0;
      end else if (flush_req) begin
        busy_q <= 1'b1;
        fl_pg  <= flush_lpn;
      end
      err_q <= fire_req && !r_en;
      if (walk_emit) begin
        ov_q   <= 1'b1;
        code_q <= RES_FLUSH;
        lpn_q  <= fl_pg;
        gpn_q  <= gpn_tab[fl_pg];
        line_q <= fs_idx;
      end else if (fire_fill && fm_hit) begin
        ov_q   <= 1'b1;
        code_q <= RES_FILL;
        lpn_q  <= fm_idx;
        gpn_q  <= fill_gpn;
        line_q <= fill_line;
      end else if (fire_req && r_en) begin
        ov_q   <= 1'b1;
        code_q <= r_bit ? RES_LOCAL : RES_FETCH;
        lpn_q  <= req_lpn;
        gpn_q  <= gpn_tab[req_lpn];
        line_q <= req_line;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign flush_busy   = busy_q;
  assign unmapped_err = err_q;
  assign out_valid    = ov_q;
  assign out_code     = code_q;
  assign out_lpn      = lpn_q;
  assign out_gpn      = gpn_q;
  assign out_line     = line_q;
endmodule

// File: rtl/pcl_lookup_chk.sv
`timescale 1ns/1ps
module pcl_lookup_chk #(
  parameter int NPAGE = 4,
  parameter int LINES = 8,
  parameter int GPN_W = 12,
  localparam int LPN_W = $clog2(NPAGE),
  localparam int LN_W  = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_busy,
  input logic             req_valid,
  input logic             req_ready,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_code,
  input logic [LPN_W-1:0] out_lpn,
  input logic [GPN_W-1:0] out_gpn,
  input logic [LN_W-1:0]  out_line,
  input logic             unmapped_err
);
  logic hold_q, new_item;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= out_valid && !out_ready;
  end
  assign new_item = out_valid && !hold_q;

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_lpn)
      && $stable(out_gpn) && $stable(out_line));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready && !fill_ready);

  // R11
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready && !fill_ready);

  // R11
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);

  // R9
  flush_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_item && out_code == 2'd3 |-> $past(flush_busy));

  // R5
  fill_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_item && out_code == 2'd2 |-> $past(fill_valid && fill_ready));

  // R2
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_item && out_code[1] == 1'b0 |-> $past(req_valid && req_ready));

  // R4
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_err |-> $past(req_valid && req_ready) && !(new_item && out_code[1] == 1'b0));
endmodule

bind pcl_lookup pcl_lookup_chk #(.NPAGE(NPAGE), .LINES(LINES), .GPN_W(GPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_busy(flush_busy),
  .req_valid(req_valid), .req_ready(req_ready),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_lpn(out_lpn), .out_gpn(out_gpn), .out_line(out_line),
  .unmapped_err(unmapped_err)
);

// File: tb/pcl_lookup_bench.sv
`timescale 1ns/1ps
module pcl_lookup_bench;
  localparam int NPAGE = 4, LINES = 8, GPN_W = 12;
  localparam int LPN_W = 2, LN_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, flush_req = 0, inv_valid = 0;
  logic [LPN_W-1:0] cfg_lpn = 0, flush_lpn = 0, req_lpn = 0;
  logic [GPN_W-1:0] cfg_gpn = 0, inv_gpn = 0, fill_gpn = 0;
  logic [LN_W-1:0]  inv_line = 0, req_line = 0, fill_line = 0;
  logic req_valid = 0, fill_valid = 0, out_ready = 1;
  logic flush_busy, req_ready, fill_ready, out_valid, unmapped_err;
  logic [1:0] out_code;
  logic [LPN_W-1:0] out_lpn;
  logic [GPN_W-1:0] out_gpn;
  logic [LN_W-1:0]  out_line;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pcl_lookup #(.NPAGE(NPAGE), .LINES(LINES), .GPN_W(GPN_W)) u_pcl_lookup (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_lpn(cfg_lpn), .cfg_gpn(cfg_gpn), .cfg_en(cfg_en),
    .flush_req(flush_req), .flush_lpn(flush_lpn), .flush_busy(flush_busy),
    .inv_valid(inv_valid), .inv_gpn(inv_gpn), .inv_line(inv_line),
    .req_valid(req_valid), .req_ready(req_ready), .req_lpn(req_lpn), .req_line(req_line),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_gpn(fill_gpn), .fill_line(fill_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_lpn(out_lpn), .out_gpn(out_gpn), .out_line(out_line),
    .unmapped_err(unmapped_err)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic expect_item(input string rq, input int code, input int lpn, input int gpn, input int line);
    chk(out_valid == 1'b1, rq, "out_valid", int'(out_valid), 1);
    chk(int'(out_code) == code, rq, "out_code", int'(out_code), code);
    chk(int'(out_lpn) == lpn, rq, "out_lpn", int'(out_lpn), lpn);
    chk(int'(out_gpn) == gpn, rq, "out_gpn", int'(out_gpn), gpn);
    chk(int'(out_line) == line, rq, "out_line", int'(out_line), line);
  endtask

  task automatic expect_none(input string rq);
    chk(out_valid == 1'b0, rq, "no item", int'(out_valid), 0);
  endtask

  task automatic cfg_write(input int lpn, input int gpn, input bit en);
    @(negedge clk);
    cfg_we = 1; cfg_lpn = LPN_W'(lpn); cfg_gpn = GPN_W'(gpn); cfg_en = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_req(input int lpn, input int line);
    @(negedge clk);
    req_valid = 1; req_lpn = LPN_W'(lpn); req_line = LN_W'(line);
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_fill(input int gpn, input int line);
    @(negedge clk);
    fill_valid = 1; fill_gpn = GPN_W'(gpn); fill_line = LN_W'(line);
    #1;
    while (!fill_ready) @(negedge clk);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic send_inv(input int gpn, input int line);
    @(negedge clk);
    inv_valid = 1; inv_gpn = GPN_W'(gpn); inv_line = LN_W'(line);
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
    chk(flush_busy == 0, "R1", "flush_busy", int'(flush_busy), 0);
    chk(unmapped_err == 0, "R1", "unmapped_err", int'(unmapped_err), 0);
    send_req(0, 0);
    chk(unmapped_err == 1, "R1", "unmapped after reset", int'(unmapped_err), 1);
    expect_none("R1");
  endtask

  task automatic t_fetch_fill;
    cfg_write(1, 'h0A3, 1);
    cfg_write(2, 'h155, 1);
    send_req(1, 3);
    expect_item("R3", 1, 1, 'h0A3, 3);
    send_req(1, 3);
    expect_item("R3", 1, 1, 'h0A3, 3);
    send_fill('h0A3, 3);
    expect_item("R5", 2, 1, 'h0A3, 3);
    send_req(1, 3);
    expect_item("R2", 0, 1, 'h0A3, 3);
    send_req(1, 4);
    expect_item("R3", 1, 1, 'h0A3, 4);
  endtask

  task automatic t_stray_fill;
    send_fill('h777, 2);
    expect_none("R6");
    send_req(2, 2);
    expect_item("R6", 1, 2, 'h155, 2);
  endtask

  task automatic t_invalidate;
    send_fill('h0A3, 5);
    expect_item("R5", 2, 1, 'h0A3, 5);
    send_inv('h0A3, 3);
    send_req(1, 3);
    expect_item("R7", 1, 1, 'h0A3, 3);
    send_req(1, 5);
    expect_item("R7", 0, 1, 'h0A3, 5);
  endtask

  task automatic t_remap;
    send_fill('h155, 0);
    expect_item("R5", 2, 2, 'h155, 0);
    send_req(2, 0);
    expect_item("R8", 0, 2, 'h155, 0);
    cfg_write(2, 'h155, 1);
    send_req(2, 0);
    expect_item("R8", 1, 2, 'h155, 0);
  endtask

  task automatic t_disabled;
    cfg_write(3, 'h300, 1);
    cfg_write(3, 'h300, 0);
    send_req(3, 1);
    chk(unmapped_err == 1, "R4", "unmapped_err", int'(unmapped_err), 1);
    expect_none("R4");
    @(negedge clk);
    chk(unmapped_err == 0, "R4", "err one cycle", int'(unmapped_err), 0);
    send_fill('h300, 1);
    expect_none("R6");
  endtask

  task automatic t_priority;
    @(negedge clk);
    fill_valid = 1; fill_gpn = 'h155; fill_line = 7;
    req_valid = 1; req_lpn = 2; req_line = 7;
    #1;
    chk(req_ready == 0, "R11", "req_ready with fill", int'(req_ready), 0);
    @(negedge clk);
    fill_valid = 0;
    expect_item("R11", 2, 2, 'h155, 7);
    @(negedge clk);
    req_valid = 0;
    expect_item("R11", 0, 2, 'h155, 7);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 0;
    send_req(2, 7);
    expect_item("R10", 0, 2, 'h155, 7);
    req_valid = 1; req_lpn = 1; req_line = 0;
    repeat (2) begin
      @(negedge clk);
      expect_item("R10", 0, 2, 'h155, 7);
      chk(req_ready == 0, "R10", "req_ready stalled", int'(req_ready), 0);
      chk(fill_ready == 0, "R10", "fill_ready stalled", int'(fill_ready), 0);
    end
    out_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_item("R10", 1, 1, 'h0A3, 0);
    @(negedge clk);
    expect_none("R10");
  endtask

  task automatic t_flush;
    int got [8];
    int n = 0;
    send_fill('h0A3, 6);
    send_fill('h0A3, 1);
    @(negedge clk);
    flush_req = 1; flush_lpn = 1;
    @(negedge clk);
    flush_req = 0;
    chk(flush_busy == 1, "R9", "flush_busy", int'(flush_busy), 1);
    chk(req_ready == 0, "R11", "req_ready in flush", int'(req_ready), 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (out_valid) begin
        chk(out_code == 2'd3, "R9", "flush code", int'(out_code), 3);
        chk(out_gpn == 'h0A3, "R9", "flush gpn", int'(out_gpn), 'h0A3);
        if (n < 8) got[n] = int'(out_line);
        n++;
      end
      if (!flush_busy && !out_valid) break;
    end
    chk(n == 3, "R9", "flush count", n, 3);
    chk(got[0] == 1, "R9", "flush line0", got[0], 1);
    chk(got[1] == 5, "R9", "flush line1", got[1], 5);
    chk(got[2] == 6, "R9", "flush line2", got[2], 6);
    chk(flush_busy == 0, "R9", "flush done", int'(flush_busy), 0);
    send_req(1, 5);
    chk(unmapped_err == 1, "R9", "unmapped after flush", int'(unmapped_err), 1);
    expect_none("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch_fill();
    t_stray_fill();
    t_invalidate();
    t_remap();
    t_disabled();
    t_priority();
    t_backpressure();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule